// File: doc/BRIEF.md
# Sticky Interrupt Aggregator

This block gathers single-cycle interrupt events from six banks of 32 pins and folds each bank into one aggregated interrupt group. For every group it keeps a sticky pending vector, a mask vector that software sets and clears through separate write addresses, and a read-only masked view. A group raises its line toward the processor interrupt controller when it has at least one pending bit that is also unmasked, and when that group's bit in a global gate register is set.

Software reaches every register through a simple 32-bit bus: a word address, a write strobe with data, and a read data path that answers combinationally from the current register state. Pending bits are cleared by writing ones, so a handler can write back the masked view it just read without read-modify-write. The six group lines are placed on non-contiguous controller input numbers.

Register map: address bits [5:2] select a bank slot (0 to 5) and bits [1:0] pick the register: 0 pending (read, write-one-to-clear), 1 mask set (write ones to unmask, reads mask), 2 mask clear (write ones to mask, reads mask), 3 masked view (read only). Slot 15 offset 0 is the gate register, read/write, where bit g gates group number g. Other addresses read zero.

Top module: `irq_collector`

## Requirements
- R1: Banks 0,1,2,3,4,5 form groups numbered 11,10,9,8,12,26; pin n of bank b is bit n of slot b's registers, and group g drives `irq_vec` bit g-8 (so vector bits 3,2,1,0,4,18 for banks 0..5).
- R2: A pin event sets its pending bit even while that bit is masked.
- R3: Writing 1 to a pending bit clears it, writing 0 leaves it unchanged, and writing all ones clears the whole group.
- R4: Writing 1s to offset 1 unmasks those bits, writing 1s to offset 2 masks them, zeros change nothing; both offsets read back the mask.
- R5: Offset 3 reads pending AND mask; writes to it have no effect.
- R6: A group's vector bit is high only when its gate bit is set and its masked view is nonzero; vector bits not assigned to a group stay 0.
- R7: An event in the same cycle as a write-one-to-clear of the same bit leaves the bit set.
- R8: A read in the cycle after a write returns the updated value with no added latency.
- R9: The group lines are registered: a line rises one clock after its masked view becomes nonzero and drops one clock after it returns to zero.
- R10: After reset all pending, mask and gate bits and all vector outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_evt | input | 192 | Event pulses, bank b pin n at bit 32*b+n |
| addr | input | 6 | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| irq_vec | output | 19 | Interrupt lines to the controller inputs |

## Verification
Events are sent to masked pins, to one distinct pin per bank, and to every bank at once; the first separates latching from masking, the second exposes any mix-up in the bank-to-slot placement, and the third exposes an error in the group-to-vector placement. Pending clears are tried with zero data, a single bit and all ones, and once in the same cycle as an event on that bit, which separates event-wins from clear-wins. The vector output is followed cycle by cycle around a clear and around the gate bit to tell a registered line from a combinational one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_BANKS = 6;
  localparam int DATA_W    = 32;
  localparam int NUM_VEC   = 19;
  localparam int ADDR_W    = 6;
  localparam int GATE_SLOT = 15;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_MSET = 2'd1,
    REG_MCLR = 2'd2,
    REG_VIEW = 2'd3
  } reg_sel_e;

  // group number fed by a pin bank
  function automatic int bank_group(input int b);
    case (b)
      0: return 11;
      1: return 10;
      2: return 9;
      3: return 8;
      4: return 12;
      default: return 26;
    endcase
  endfunction

  // controller input driven by a group
  function automatic int group_line(input int g);
    return g - 8;
  endfunction

  function automatic logic [DATA_W-1:0] pend_next(input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] clr,
                                                  input logic [DATA_W-1:0] evt);
    return (cur & ~clr) | evt;
  endfunction

  function automatic logic [DATA_W-1:0] mask_next(input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] set,
                                                  input logic [DATA_W-1:0] clr);
    return (cur | set) & ~clr;
  endfunction
endpackage

// File: rtl/irqc_group.sv
module irqc_group
  import irqc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] pend_clr,
  input  logic [W-1:0] mask_set,
  input  logic [W-1:0] mask_clr,
  input  logic         gate,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] view,
  output logic         line
);
  logic view_any;

  assign view     = pend & mask;
  assign view_any = |view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
      line <= 1'b0;
    end else begin
      pend <= pend_next(pend, pend_clr, evt);
      mask <= mask_next(mask, mask_set, mask_clr);
      line <= gate & view_any;
    end
  end

  // R2 / R7: every event is latched, whatever the mask or a clear
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
  // R3: set bits that were not written with 1 stay set
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~pend_clr)) == $past(pend & ~pend_clr)));
  // R4: mask bits move only where a set or clear strobe had a one
  a_r4_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask ^ $past(mask)) & ~$past(mask_set | mask_clr)) == '0));
  // R9: the line drops one clock after the view is empty
  a_r9_line_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (view == '0) |=> !line);
  // R6: gate low forces the line low next cycle
  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !line);
endmodule

// File: rtl/irqc_linemap.sv
module irqc_linemap
  import irqc_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int NV = NUM_VEC
) (
  input  logic [NB-1:0] grp_line,
  output logic [NV-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int b = 0; b < NB; b++) begin
      vec[group_line(bank_group(b))] = grp_line[b];
    end
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int W  = DATA_W,
  parameter int NV = NUM_VEC,
  parameter int AW = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB*W-1:0] pin_evt,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    rd_data,
  output logic [NV-1:0]   irq_vec
);
  localparam int SLOT_W = AW - 2;

  logic [SLOT_W-1:0] slot;
  reg_sel_e          rsel;
  logic [W-1:0]      gate_q;
  logic [W-1:0]      pend_a [NB];
  logic [W-1:0]      mask_a [NB];
  logic [W-1:0]      view_a [NB];
  logic [NB-1:0]     grp_line;
  logic              gate_wr;

  assign slot    = addr[AW-1:2];
  assign rsel    = reg_sel_e'(addr[1:0]);
  assign gate_wr = wr_en && (slot == SLOT_W'(GATE_SLOT)) && (rsel == REG_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= '0;
    else if (gate_wr) gate_q <= wr_data;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (slot == SLOT_W'(b));
    irqc_group #(.W(W)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (pin_evt[b*W +: W]),
      .pend_clr ((hit && rsel == REG_PEND) ? wr_data : '0),
      .mask_set ((hit && rsel == REG_MSET) ? wr_data : '0),
      .mask_clr ((hit && rsel == REG_MCLR) ? wr_data : '0),
      .gate     (gate_q[bank_group(b)]),
      .pend     (pend_a[b]),
      .mask     (mask_a[b]),
      .view     (view_a[b]),
      .line     (grp_line[b])
    );
  end

  always_comb begin
    rd_data = '0;
    if (slot == SLOT_W'(GATE_SLOT) && rsel == REG_PEND) begin
      rd_data = gate_q;
    end
    for (int b = 0; b < NB; b++) begin
      if (slot == SLOT_W'(b)) begin
        case (rsel)
          REG_PEND: rd_data = pend_a[b];
          REG_MSET,
          REG_MCLR: rd_data = mask_a[b];
          default:  rd_data = view_a[b];
        endcase
      end
    end
  end

  irqc_linemap #(.NB(NB), .NV(NV)) u_map (
    .grp_line (grp_line),
    .vec      (irq_vec)
  );

  // R6: with every gate bit low, no line is raised next cycle
  a_r6_all_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q == '0) |=> (irq_vec == '0));
  // R10: one cycle after reset release nothing is pending on the outputs
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_vec == '0));
endmodule

// File: tb/irq_collector_test.sv
module irq_collector_test;
  localparam int NB = 6;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*W-1:0] pin_evt = '0;
  logic [5:0]      addr = '0;
  logic            wr_en = 1'b0;
  logic [W-1:0]    wr_data = '0;
  logic [W-1:0]    rd_data;
  logic [18:0]     irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  irq_collector uut (
    .clk(clk), .rst_n(rst_n), .pin_evt(pin_evt), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_vec(irq_vec)
  );

  always #5 clk = ~clk;

  function automatic logic [5:0] ad(input int s, input int r);
    return 6'((s << 2) | r);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock: inputs set before the call, cleared after the edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    pin_evt = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step();
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    for (int s = 0; s < NB; s++) begin
      rd("R10 pend", ad(s, 0), 32'h0);
      rd("R10 mask", ad(s, 1), 32'h0);
    end
    rd("R10 gate", ad(15, 0), 32'h0);
    chk("R10 vec", 32'(irq_vec), 32'h0);
  endtask

  task automatic t_latch_masked();
    for (int b = 0; b < NB; b++) pin_evt[b*W + b*5 + 1] = 1'b1;
    step();
    for (int b = 0; b < NB; b++) begin
      rd("R1 R2 pend slot", ad(b, 0), 32'(1) << (b*5 + 1));
      rd("R2 view masked", ad(b, 3), 32'h0);
    end
    step();
    chk("R2 no line", 32'(irq_vec), 32'h0);
  endtask

  task automatic t_clear();
    wr(ad(2, 0), 32'h0);
    rd("R3 zero keeps", ad(2, 0), 32'h800);
    pin_evt[2*W + 20] = 1'b1;
    step();
    wr(ad(2, 0), 32'h800);
    rd("R3 R8 single clear", ad(2, 0), 32'h0010_0000);
    for (int b = 0; b < NB; b++) wr(ad(b, 0), 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) rd("R3 all ones", ad(b, 0), 32'h0);
  endtask

  task automatic t_mask();
    wr(ad(1, 1), 32'h0000_00F0);
    wr(ad(1, 1), 32'h0000_0003);
    rd("R4 set", ad(1, 1), 32'h0000_00F3);
    wr(ad(1, 2), 32'h0000_0010);
    rd("R4 clr via 1", ad(1, 1), 32'h0000_00E3);
    rd("R4 clr via 2", ad(1, 2), 32'h0000_00E3);
    wr(ad(1, 2), 32'hFFFF_FFFF);
    rd("R4 all masked", ad(1, 1), 32'h0);
  endtask

  task automatic t_line_timing();
    wr(ad(15, 0), 32'h0400_0000);          // gate group 26
    wr(ad(5, 1), 32'h0000_0080);
    pin_evt[5*W + 7] = 1'b1;
    pin_evt[5*W + 9] = 1'b1;
    step();
    rd("R5 view", ad(5, 3), 32'h0000_0080);
    chk("R9 not yet", 32'(irq_vec), 32'h0);
    wr(ad(5, 3), 32'hFFFF_FFFF);           // write to view ignored
    rd("R5 view write ignored", ad(5, 0), 32'h0000_0280);
    chk("R6 R9 line up", 32'(irq_vec), 32'h0004_0000);
    wr(ad(5, 0), 32'h0000_0080);
    chk("R9 still up", 32'(irq_vec), 32'h0004_0000);
    step();
    chk("R9 dropped", 32'(irq_vec), 32'h0);
    pin_evt[5*W + 7] = 1'b1;
    step(); step();
    chk("R6 relatch", 32'(irq_vec), 32'h0004_0000);
    wr(ad(15, 0), 32'h0);
    step();
    chk("R6 gate off", 32'(irq_vec), 32'h0);
    wr(ad(5, 0), 32'hFFFF_FFFF);
  endtask

  task automatic t_all_banks();
    wr(ad(15, 0), 32'h0400_1F00);
    for (int b = 0; b < NB; b++) wr(ad(b, 1), 32'h8000_0000);
    for (int b = 0; b < NB; b++) pin_evt[b*W + 31] = 1'b1;
    step(); step();
    chk("R1 R6 all lines", 32'(irq_vec), 32'h0004_001F);
    wr(ad(3, 0), 32'h8000_0000);           // bank 3 = group 8 = line 0
    step();
    chk("R1 bank3 line0", 32'(irq_vec), 32'h0004_001E);
    wr(ad(0, 0), 32'h8000_0000);           // bank 0 = group 11 = line 3
    step();
    chk("R1 bank0 line3", 32'(irq_vec), 32'h0004_0016);
  endtask

  task automatic t_race();
    pin_evt[4*W + 3] = 1'b1;
    step();
    addr = ad(4, 0); wr_data = 32'h0000_0008; wr_en = 1'b1;
    pin_evt[4*W + 3] = 1'b1;
    step();
    rd("R7 event wins", ad(4, 0), 32'h8000_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_masked();
    t_clear();
    t_mask();
    t_line_timing();
    t_all_banks();
    t_race();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule